// File: doc/BRIEF.md
# Power-Up Output Short Check Sequencer

This block sequences the one-time output short test of a multi-channel switching amplifier. When the logic supply becomes ready after a power-on reset, it first drives the test that looks for any output tied to ground. It then drives the test that looks for any output tied to the power-stage supply. Only when both tests find no short does it grant the power stage permission to switch. While the test runs, every half-bridge is held in high impedance and a fault request keeps the shared fault line asserted.

Each test step ends either on a done pulse from the analog test circuitry or on a timeout. The timeout length comes from the clock rate and the output filter capacitance, at roughly fifteen milliseconds per microfarad. If a comparator flags a short when a step ends, that same step is repeated until the short is gone, and all bridges stay in high impedance meanwhile. The sequence then continues. The device reset input has no effect while testing. After the sequence completes, the device reset input only gates the switching grant and never starts a new test. Output configurations that include single-ended outputs skip the test altogether.

Top module: `short_check_seq`

## Requirements
- R1: After `rst`, the block idles with `hiz_all`=1 and `test_drv_gnd`, `test_drv_pwr`, `fault_req`, `switch_grant` all 0, and stays there while `supply_ok` is 0.
- R2: With `supply_ok`=1 in a bridge mode (`mode` 2'b00 stereo bridge or 2'b10 paralleled bridge), the ground step begins one clock later: `test_drv_gnd`=1, `fault_req`=1, `hiz_all`=1. The power-supply step can only follow the ground step.
- R3: A step ends on a `step_done` pulse, or after `STEP_CYC` cycles in the step (15 with the default parameters). A ground step that ends with `gnd_short` all zero moves on to the power-supply step (`test_drv_pwr`=1).
- R4: If any bit of the current step's short vector (`gnd_short` in the ground step, `pwr_short` in the supply step) is 1 when the step ends, the same step repeats. `hiz_all` stays 1 and `switch_grant` stays 0. Once the short clears, the sequence goes on.
- R5: A supply step that ends with `pwr_short` all zero completes the sequence: `switch_grant`=1, `hiz_all`=0, `fault_req`=0, and both test drives are 0 (with `dev_rst_n`=1).
- R6: While a step is running, `dev_rst_n` has no effect on any output or on the sequence.
- R7: In `mode` 2'b01 or 2'b11 (modes containing single-ended outputs), the sequence skips both steps and completes one clock after `supply_ok`. No test drive is ever raised.
- R8: Completion is final until `rst`. Later shorts and `step_done` pulses are ignored, and `dev_rst_n` never restarts a test. After completion, `switch_grant` equals `dev_rst_n` and `hiz_all` equals its inverse.
- R9: At most one test drive is active at a time, and `fault_req` is 1 exactly while a step runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| supply_ok | input | 1 | Logic supply ready |
| mode | input | 2 | Output configuration code |
| dev_rst_n | input | 1 | Device reset input, active low |
| step_done | input | 1 | Current test step has settled |
| gnd_short | input | N_OUT | Per-output short-to-ground comparator result |
| pwr_short | input | N_OUT | Per-output short-to-supply comparator result |
| test_drv_gnd | output | 1 | Enable for the ground-short test drive |
| test_drv_pwr | output | 1 | Enable for the supply-short test drive |
| hiz_all | output | 1 | Hold every half-bridge in high impedance |
| fault_req | output | 1 | Request to assert the fault line |
| switch_grant | output | 1 | Power stage may start switching |

## Verification
The embedded properties check on every cycle that the two test drives never overlap and that the supply step is only entered from the ground step. They also check that a step ending with a short keeps the sequencer in that step, that completion never reverts, and that the step timer never passes its limit. The directed scenarios are needed for the rest. They show the exact timeout length, the retry of a failing step and then the resumption of the sequence, that the skip happens in both single-ended modes, and that the device reset input has no effect during the test but gates the grant afterwards.

// File: rtl/sq_pkg.sv
package sq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GND  = 2'd1,
        ST_PWR  = 2'd2,
        ST_DONE = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        MD_BRIDGE2 = 2'b00,
        MD_MIXED   = 2'b01,
        MD_PARALL  = 2'b10,
        MD_SINGLE4 = 2'b11
    } amp_mode_e;

    typedef struct packed {
        logic ended;
        logic short_hit;
    } step_res_t;

    function automatic logic mode_runs_check(input logic [1:0] m);
        logic r;
        case (m)
            MD_BRIDGE2: r = 1'b1;
            MD_PARALL:  r = 1'b1;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic int step_cycles(input int clk_khz, input int cap_nf,
                                       input int ms_per_uf);
        int c;
        c = (ms_per_uf * cap_nf * clk_khz) / 1000;
        if (c < 1) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/sq_step_timer.sv
module sq_step_timer #(
    parameter int STEP_CYC = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic step_done,
    output logic step_end
);
    localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign step_end = run && (step_done || (cnt_q == LAST));

    always_ff @(posedge clk) begin
        if (rst || !run || step_end)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R3: the step counter never runs past its last value
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/sq_short_eval.sv
module sq_short_eval
    import sq_pkg::*;
#(
    parameter int N_OUT = 4
) (
    input  seq_state_e       state,
    input  logic             step_end,
    input  logic [N_OUT-1:0] gnd_short,
    input  logic [N_OUT-1:0] pwr_short,
    output step_res_t        res
);
    logic [N_OUT-1:0] hit_vec;

    generate
        for (genvar i = 0; i < N_OUT; i++) begin : g_out
            always_comb begin
                case (state)
                    ST_GND:  hit_vec[i] = gnd_short[i];
                    ST_PWR:  hit_vec[i] = pwr_short[i];
                    default: hit_vec[i] = 1'b0;
                endcase
            end
        end
    endgenerate

    always_comb begin
        res.ended     = step_end;
        res.short_hit = |hit_vec;
    end

endmodule

// File: rtl/sq_ctrl.sv
module sq_ctrl
    import sq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok,
    input  logic [1:0] mode,
    input  logic       dev_rst_n,
    input  step_res_t  res,
    output seq_state_e state,
    output logic       test_drv_gnd,
    output logic       test_drv_pwr,
    output logic       hiz_all,
    output logic       fault_req,
    output logic       switch_grant
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (supply_ok)
                         state_d = mode_runs_check(mode) ? ST_GND : ST_DONE;
            ST_GND:  if (res.ended && !res.short_hit) state_d = ST_PWR;
            ST_PWR:  if (res.ended && !res.short_hit) state_d = ST_DONE;
            default: state_d = ST_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state        = state_q;
        test_drv_gnd = (state_q == ST_GND);
        test_drv_pwr = (state_q == ST_PWR);
        fault_req    = (state_q == ST_GND) || (state_q == ST_PWR);
        switch_grant = (state_q == ST_DONE) && dev_rst_n;
        hiz_all      = !switch_grant;
    end

    // R2: the supply step is entered only from the ground step
    a_r2_pwr_after_gnd: assert property (@(posedge clk) disable iff (rst)
        $rose(test_drv_pwr) |-> $past(test_drv_gnd));

    // R4: a step that ends with a short is repeated
    a_r4_short_retries: assert property (@(posedge clk) disable iff (rst)
        (fault_req && res.ended && res.short_hit) |=> $stable(state_q));

    // R8: completion is final
    a_r8_done_final: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE) |=> (state_q == ST_DONE));

    // R7: single-ended modes go straight to completion
    a_r7_skip_se: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && supply_ok && mode[0]) |=> !fault_req);

endmodule

// File: rtl/short_check_seq.sv
module short_check_seq
    import sq_pkg::*;
#(
    parameter int N_OUT     = 4,
    parameter int CLK_KHZ   = 100,
    parameter int FILT_NF   = 10,
    parameter int MS_PER_UF = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             supply_ok,
    input  logic [1:0]       mode,
    input  logic             dev_rst_n,
    input  logic             step_done,
    input  logic [N_OUT-1:0] gnd_short,
    input  logic [N_OUT-1:0] pwr_short,
    output logic             test_drv_gnd,
    output logic             test_drv_pwr,
    output logic             hiz_all,
    output logic             fault_req,
    output logic             switch_grant
);
    localparam int STEP_CYC = step_cycles(CLK_KHZ, FILT_NF, MS_PER_UF);

    seq_state_e state;
    step_res_t  res;
    logic       step_end;

    sq_step_timer #(.STEP_CYC(STEP_CYC)) i_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (fault_req),
        .step_done (step_done),
        .step_end  (step_end)
    );

    sq_short_eval #(.N_OUT(N_OUT)) i_eval (
        .state     (state),
        .step_end  (step_end),
        .gnd_short (gnd_short),
        .pwr_short (pwr_short),
        .res       (res)
    );

    sq_ctrl i_ctrl (
        .clk          (clk),
        .rst          (rst),
        .supply_ok    (supply_ok),
        .mode         (mode),
        .dev_rst_n    (dev_rst_n),
        .res          (res),
        .state        (state),
        .test_drv_gnd (test_drv_gnd),
        .test_drv_pwr (test_drv_pwr),
        .hiz_all      (hiz_all),
        .fault_req    (fault_req),
        .switch_grant (switch_grant)
    );

    // R9: test drives never overlap
    a_r9_one_drive: assert property (@(posedge clk) disable iff (rst)
        !(test_drv_gnd && test_drv_pwr));

endmodule

// File: tb/test_short_check_seq.sv
module test_short_check_seq;
    localparam int CLK_PERIOD = 10;
    localparam int N_OUT      = 4;
    localparam int STEP_CYC   = (15 * 10 * 100) / 1000;

    // packed view: {drv_gnd, drv_pwr, hiz, fault, grant}
    localparam logic [4:0] O_IDLE  = 5'b00100;
    localparam logic [4:0] O_GND   = 5'b10110;
    localparam logic [4:0] O_PWR   = 5'b01110;
    localparam logic [4:0] O_DONE  = 5'b00001;
    localparam logic [4:0] O_DRST  = 5'b00100;

    logic clk = 1'b0;
    logic rst, supply_ok, dev_rst_n, step_done;
    logic [1:0] mode;
    logic [N_OUT-1:0] gnd_short, pwr_short;
    logic test_drv_gnd, test_drv_pwr, hiz_all, fault_req, switch_grant;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    short_check_seq #(.N_OUT(N_OUT)) i_short_check_seq (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .mode(mode),
        .dev_rst_n(dev_rst_n), .step_done(step_done),
        .gnd_short(gnd_short), .pwr_short(pwr_short),
        .test_drv_gnd(test_drv_gnd), .test_drv_pwr(test_drv_pwr),
        .hiz_all(hiz_all), .fault_req(fault_req), .switch_grant(switch_grant)
    );

    function automatic logic [4:0] outs();
        return {test_drv_gnd, test_drv_pwr, hiz_all, fault_req, switch_grant};
    endfunction

    task automatic check(input string req, input logic [4:0] exp);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL %s: outputs %b expected %b at %0t", req, outs(), exp, $time);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst = 1'b1; supply_ok = 1'b0; mode = m; dev_rst_n = 1'b1;
        step_done = 1'b0; gnd_short = '0; pwr_short = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_done();
        step_done = 1'b1;
        @(negedge clk);
        step_done = 1'b0;
    endtask

    task automatic power_up();
        supply_ok = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset(2'b00);
        check("R1 idle after reset", O_IDLE);
        repeat (5) @(negedge clk);
        check("R1 idle while supply low", O_IDLE);
    endtask

    task automatic t_clean_pass();
        do_reset(2'b00);
        power_up();
        check("R2 ground step entered", O_GND);
        check("R9 fault during ground step", O_GND);
        dev_rst_n = 1'b0;
        @(negedge clk);
        check("R6 device reset low ignored in step", O_GND);
        dev_rst_n = 1'b1;
        @(negedge clk);
        check("R6 device reset high ignored in step", O_GND);
        pulse_done();
        check("R3 ground pass to supply step", O_PWR);
        dev_rst_n = 1'b0;
        @(negedge clk);
        check("R6 device reset ignored in supply step", O_PWR);
        dev_rst_n = 1'b1;
        pulse_done();
        check("R5 sequence complete", O_DONE);
        // R8: later activity must not restart the test
        gnd_short = 4'b1111; pwr_short = 4'b1111;
        pulse_done();
        repeat (STEP_CYC + 2) @(negedge clk);
        check("R8 later shorts ignored", O_DONE);
        dev_rst_n = 1'b0;
        @(negedge clk);
        check("R8 device reset gates grant", O_DRST);
        repeat (3) @(negedge clk);
        dev_rst_n = 1'b1;
        @(negedge clk);
        check("R8 device reset release no retest", O_DONE);
    endtask

    task automatic t_short_retry();
        do_reset(2'b10);
        power_up();
        check("R2 ground step in paralleled mode", O_GND);
        gnd_short = 4'b0100;
        pulse_done();
        check("R4 ground short repeats step", O_GND);
        pulse_done();
        check("R4 ground short still held", O_GND);
        gnd_short = '0;
        pulse_done();
        check("R4 ground clear continues", O_PWR);
        pwr_short = 4'b0001;
        pulse_done();
        check("R4 supply short repeats step", O_PWR);
        repeat (STEP_CYC + 1) @(negedge clk);
        check("R4 supply short held past timeout", O_PWR);
        pwr_short = '0;
        pulse_done();
        check("R4 supply clear completes", O_DONE);
    endtask

    task automatic t_timeout();
        do_reset(2'b00);
        power_up();
        check("R3 timeout ground start", O_GND);
        repeat (STEP_CYC - 1) @(negedge clk);
        check("R3 ground step before timeout", O_GND);
        @(negedge clk);
        check("R3 ground step ends on timeout", O_PWR);
        repeat (STEP_CYC - 1) @(negedge clk);
        check("R3 supply step before timeout", O_PWR);
        @(negedge clk);
        check("R3 supply step ends on timeout", O_DONE);
    endtask

    task automatic t_skip(input logic [1:0] m);
        do_reset(m);
        gnd_short = 4'b1111; pwr_short = 4'b1111;
        power_up();
        check("R7 single-ended mode skips test", O_DONE);
        repeat (STEP_CYC + 2) @(negedge clk);
        check("R7 skip stays complete", O_DONE);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; supply_ok = 1'b0; mode = 2'b00; dev_rst_n = 1'b1;
        step_done = 1'b0; gnd_short = '0; pwr_short = '0;
        t_reset();
        t_clean_pass();
        t_short_retry();
        t_timeout();
        t_skip(2'b11);
        t_skip(2'b01);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule